// File: doc/BRIEF.md
# Action-Sequence Waveform Pin Driver

This block drives one tester pin. A tester cycle is divided into a fixed number of clock slots. Six timing edges each hold one slot position. Eight stored waveforms each hold up to four steps. A step names an edge and an action. In each cycle a selector value picks one waveform, and its steps are carried out at the slots of the edges they name.

An edge is only a position. Any waveform may attach any action to it. To shift a transition in time, a waveform applies the same action on another edge, so the edge registers never need rewriting between cycles. Consecutive cycles can place activity in the last slot of one cycle and the first slot of the next with no dead slot between them. Each instance keeps its own edges, waveforms and selector, so pins that serve independent device buses run independent timing.

Configuration is written one word per clock through a small write port. The edge registers and the step memory are stored in flops.

Top module: `wfd_pin_driver`

## Requirements
- R1: While reset is asserted, and in the first slot after reset is released, `pin_o`=0, `oe_o`=0 and `err_o`=0. The slot counter is at slot 0, so `cyc_o`=1, and all eight waveforms contain only end steps.
- R2: A tester cycle lasts 8 clocks. `cyc_o` is 1 in slot 0 of each cycle and 0 in the other seven slots.
- R3: `sel_i` is sampled only at the clock edge that ends slot 7, and it selects the waveform for the whole next cycle. Values on `sel_i` in any other slot have no effect.
- R4: A step word has the edge index in bits [4:2] and the action in bits [1:0]. The actions are:
  - 0 drives low (`oe_o`=1, `pin_o`=0).
  - 1 drives high.
  - 2 releases the pin (`oe_o`=0, `pin_o` keeps its value).
  - 3 toggles `pin_o` and drives it.
- R5: A step on an edge at slot position p shows at the outputs from slot p+1 onward. A step at position 7 shows from slot 0 of the next cycle.
- R6: Steps run in step order. A step with edge index 7 ends the sequence, and the steps after it are ignored.
- R7: A step whose edge position is lower than the position of the last executed step is out of order. It is skipped and `err_o` is 1 for the whole cycle. A step with edge index 6 is also skipped and also raises `err_o`.
- R8: Steps that fall on the same slot apply in step order within that one clock. Two toggles cancel each other, and a later drive or release overrides an earlier one.
- R9: The same action placed on a different edge moves the transition to that edge's slot. Rewriting an edge register moves every step that names that edge. Activity in slot 7 of one cycle and slot 0 of the next both take effect.
- R10: Two instances given different configurations and different selector streams produce outputs that each depend only on their own inputs.
- R11: When `cfg_addr_i`[5]=0, the write goes to a step: `cfg_addr_i`[4:2] is the waveform and [1:0] is the step. When `cfg_addr_i`[5]=1, `cfg_addr_i`[2:0] names an edge and `cfg_wdata_i`[2:0] is its slot position. Edge numbers 6 and 7 are ignored.
- R12: Between executed steps, `pin_o` and `oe_o` hold their values, including across cycle boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one slot per period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Waveform selector for the next tester cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration address (edge or step) |
| cfg_wdata_i | input | 5 | Configuration data (step word or edge position) |
| pin_o | output | 1 | Pin drive value |
| oe_o | output | 1 | Pin drive enable |
| err_o | output | 1 | Active waveform has a skipped out-of-order or invalid step |
| cyc_o | output | 1 | High in slot 0 of each tester cycle |

## Verification
The latencies are fixed:
- A value on `sel_i` is taken at the edge that ends slot 7, so the waveform it chooses governs slot 0 through slot 7 of the following cycle.
- An action at edge position p changes `pin_o` and `oe_o` one clock later, from slot p+1.
- `err_o` follows the active waveform for the whole cycle.

The bench samples every slot at the falling clock edge. Before each comparison it advances its own arithmetic model only through slot s-1. It sets the next selector at the falling edge of slot 7 and drives junk selector values in all other slots. Configuration writes are issued only while the idle waveform 0 is running, so no write lands in the middle of an active sequence.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam int EDGE_W = 3;
  localparam logic [EDGE_W-1:0] EDGE_END = 3'd7;

  typedef enum logic [1:0] {
    ACT_LOW    = 2'd0,
    ACT_HIGH   = 2'd1,
    ACT_OFF    = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef struct packed {
    logic [EDGE_W-1:0] edge_idx;
    act_e              act;
  } step_t;

  localparam int STEP_BITS = $bits(step_t);
endpackage

// File: rtl/wfd_slot_timer.sv
module wfd_slot_timer #(
  parameter  int NSLOT  = 8,
  parameter  int NWAVE  = 8,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int WAVE_W = $clog2(NWAVE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAVE_W-1:0] sel_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WAVE_W-1:0] wave_o,
  output logic              cyc_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [WAVE_W-1:0] wave_q;
  logic              last_slot;

  assign last_slot = (slot_q == LAST_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      wave_q <= '0;
    end else if (last_slot) begin
      slot_q <= '0;
      wave_q <= sel_i;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o = slot_q;
  assign wave_o = wave_q;
  assign cyc_o  = (slot_q == '0);
endmodule

// File: rtl/wfd_seq_mem.sv
module wfd_seq_mem import wfd_pkg::*; #(
  parameter  int NEDGE   = 6,
  parameter  int NWAVE   = 8,
  parameter  int NSTEP   = 4,
  parameter  int NSLOT   = 8,
  localparam int SLOT_W  = $clog2(NSLOT),
  localparam int WAVE_W  = $clog2(NWAVE),
  localparam int STEP_IW = $clog2(NSTEP),
  localparam int SADDR_W = WAVE_W + STEP_IW,
  localparam int CFG_AW  = 1 + ((SADDR_W > EDGE_W) ? SADDR_W : EDGE_W),
  localparam int CFG_DW  = (SLOT_W > STEP_BITS) ? SLOT_W : STEP_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic [WAVE_W-1:0] wave_i,
  output step_t             steps_o    [NSTEP],
  output logic [SLOT_W-1:0] edge_pos_o [NEDGE]
);
  localparam logic [EDGE_W-1:0] NEDGE_L  = EDGE_W'(NEDGE);
  localparam step_t             STEP_RST = '{edge_idx: EDGE_END, act: ACT_LOW};

  step_t             mem_q  [NWAVE][NSTEP];
  logic [SLOT_W-1:0] edge_q [NEDGE];

  logic               is_edge;
  logic [WAVE_W-1:0]  wr_wave;
  logic [STEP_IW-1:0] wr_step;
  logic [EDGE_W-1:0]  wr_edge;

  assign is_edge = cfg_addr_i[CFG_AW-1];
  assign wr_wave = cfg_addr_i[STEP_IW +: WAVE_W];
  assign wr_step = cfg_addr_i[0 +: STEP_IW];
  assign wr_edge = cfg_addr_i[0 +: EDGE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWAVE; w++)
        for (int s = 0; s < NSTEP; s++)
          mem_q[w][s] <= STEP_RST;
    end else if (cfg_we_i && !is_edge) begin
      mem_q[wr_wave][wr_step] <= step_t'(cfg_wdata_i[STEP_BITS-1:0]);
    end
  end

  // edge numbers at or above NEDGE are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NEDGE; e++) edge_q[e] <= '0;
    end else if (cfg_we_i && is_edge && (wr_edge < NEDGE_L)) begin
      edge_q[wr_edge] <= cfg_wdata_i[SLOT_W-1:0];
    end
  end

  for (genvar k = 0; k < NSTEP; k++) begin : g_rd
    assign steps_o[k] = mem_q[wave_i][k];
  end

  for (genvar e = 0; e < NEDGE; e++) begin : g_edge
    assign edge_pos_o[e] = edge_q[e];
  end
endmodule

// File: rtl/wfd_step_exec.sv
module wfd_step_exec import wfd_pkg::*; #(
  parameter  int NEDGE  = 6,
  parameter  int NSTEP  = 4,
  parameter  int NSLOT  = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  step_t             steps_i    [NSTEP],
  input  logic [SLOT_W-1:0] edge_pos_i [NEDGE],
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              pin_i,
  input  logic              oe_i,
  output logic              pin_o,
  output logic              oe_o,
  output logic              hit_o,
  output logic              err_o
);
  localparam logic [EDGE_W-1:0] NEDGE_L = EDGE_W'(NEDGE);

  logic              stop;
  logic              nxt_pin, nxt_oe;
  logic [SLOT_W-1:0] last_pos, pos;

  // walk the steps in order; ordering check is slot independent
  always_comb begin
    stop     = 1'b0;
    last_pos = '0;
    pos      = '0;
    nxt_pin  = pin_i;
    nxt_oe   = oe_i;
    hit_o    = 1'b0;
    err_o    = 1'b0;
    for (int k = 0; k < NSTEP; k++) begin
      if (!stop) begin
        if (steps_i[k].edge_idx == EDGE_END) begin
          stop = 1'b1;
        end else if (steps_i[k].edge_idx >= NEDGE_L) begin
          err_o = 1'b1;
        end else begin
          pos = edge_pos_i[steps_i[k].edge_idx];
          if (pos < last_pos) begin
            err_o = 1'b1;
          end else begin
            last_pos = pos;
            if (pos == slot_i) begin
              hit_o = 1'b1;
              unique case (steps_i[k].act)
                ACT_LOW:    begin nxt_pin = 1'b0;     nxt_oe = 1'b1; end
                ACT_HIGH:   begin nxt_pin = 1'b1;     nxt_oe = 1'b1; end
                ACT_OFF:    begin                     nxt_oe = 1'b0; end
                ACT_TOGGLE: begin nxt_pin = ~nxt_pin; nxt_oe = 1'b1; end
                default:    begin end
              endcase
            end
          end
        end
      end
    end
    pin_o = nxt_pin;
    oe_o  = nxt_oe;
  end
endmodule

// File: rtl/wfd_pin_driver.sv
module wfd_pin_driver import wfd_pkg::*; #(
  parameter  int NEDGE   = 6,
  parameter  int NWAVE   = 8,
  parameter  int NSTEP   = 4,
  parameter  int NSLOT   = 8,
  localparam int SLOT_W  = $clog2(NSLOT),
  localparam int WAVE_W  = $clog2(NWAVE),
  localparam int STEP_IW = $clog2(NSTEP),
  localparam int SADDR_W = WAVE_W + STEP_IW,
  localparam int CFG_AW  = 1 + ((SADDR_W > EDGE_W) ? SADDR_W : EDGE_W),
  localparam int CFG_DW  = (SLOT_W > STEP_BITS) ? SLOT_W : STEP_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAVE_W-1:0] sel_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              pin_o,
  output logic              oe_o,
  output logic              err_o,
  output logic              cyc_o
);
  logic [SLOT_W-1:0] slot_w;
  logic [WAVE_W-1:0] wave_w;
  step_t             steps_w [NSTEP];
  logic [SLOT_W-1:0] edge_w  [NEDGE];
  logic              nxt_pin, nxt_oe, hit_w, err_w;
  logic              pin_q, oe_q;

  wfd_slot_timer #(.NSLOT(NSLOT), .NWAVE(NWAVE)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .slot_o (slot_w),
    .wave_o (wave_w),
    .cyc_o  (cyc_o)
  );

  wfd_seq_mem #(.NEDGE(NEDGE), .NWAVE(NWAVE), .NSTEP(NSTEP), .NSLOT(NSLOT)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .wave_i      (wave_w),
    .steps_o     (steps_w),
    .edge_pos_o  (edge_w)
  );

  wfd_step_exec #(.NEDGE(NEDGE), .NSTEP(NSTEP), .NSLOT(NSLOT)) u_exec (
    .steps_i    (steps_w),
    .edge_pos_i (edge_w),
    .slot_i     (slot_w),
    .pin_i      (pin_q),
    .oe_i       (oe_q),
    .pin_o      (nxt_pin),
    .oe_o       (nxt_oe),
    .hit_o      (hit_w),
    .err_o      (err_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pin_q <= nxt_pin;
      oe_q  <= nxt_oe;
    end
  end

  assign pin_o = pin_q;
  assign oe_o  = oe_q;
  assign err_o = err_w;
endmodule

// File: rtl/wfd_pin_driver_chk.sv
module wfd_pin_driver_chk #(
  parameter  int NSLOT  = 8,
  parameter  int NWAVE  = 8,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int WAVE_W = $clog2(NWAVE)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] slot_i,
  input logic [WAVE_W-1:0] wave_i,
  input logic              hit_i,
  input logic              pin_i,
  input logic              oe_i,
  input logic              cyc_i
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

  a_r2_cyc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i |=> !cyc_i);

  a_r2_wrap_to_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == LAST_SLOT) |=> cyc_i);

  a_r2_slot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != LAST_SLOT) |=> (slot_i == $past(slot_i) + 1'b1));

  a_r3_wave_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != LAST_SLOT) |=> $stable(wave_i));

  a_r12_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> ($stable(pin_i) && $stable(oe_i)));
endmodule

bind wfd_pin_driver wfd_pin_driver_chk #(.NSLOT(NSLOT), .NWAVE(NWAVE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .slot_i (slot_w),
  .wave_i (wave_w),
  .hit_i  (hit_w),
  .pin_i  (pin_o),
  .oe_i   (oe_o),
  .cyc_i  (cyc_o)
);

// File: tb/tb_wfd_pin_driver.sv
module tb_wfd_pin_driver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_s [2];
  logic       we_s  [2];
  logic [5:0] cfg_addr = '0;
  logic [4:0] cfg_wdata = '0;
  logic       pin_s [2];
  logic       oe_s  [2];
  logic       err_s [2];
  logic       cyc_s [2];

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  logic [2:0] m_edge [2][6];
  logic [4:0] m_step [2][8][4];
  logic       exp_pin [2];
  logic       exp_oe  [2];
  int         cur_w   [2];

  always #5 clk = ~clk;

  wfd_pin_driver dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel_s[0]), .cfg_we_i(we_s[0]),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .pin_o(pin_s[0]), .oe_o(oe_s[0]), .err_o(err_s[0]), .cyc_o(cyc_s[0])
  );

  wfd_pin_driver dut_b (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel_s[1]), .cfg_we_i(we_s[1]),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .pin_o(pin_s[1]), .oe_o(oe_s[1]), .err_o(err_s[1]), .cyc_o(cyc_s[1])
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  // R7 R6: ordering and end-marker rules of the model
  function automatic logic model_err(int p, int w);
    logic [2:0] last = 3'd0;
    logic       bad  = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] ix = m_step[p][w][k][4:2];
      if (ix == 3'd7) break;
      if (ix == 3'd6) bad = 1'b1;
      else if (m_edge[p][ix] < last) bad = 1'b1;
      else last = m_edge[p][ix];
    end
    return bad;
  endfunction

  // R4 R5 R8: apply steps falling on slot s
  task automatic model_slot(int p, int w, int s);
    logic [2:0] last = 3'd0;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] ix = m_step[p][w][k][4:2];
      logic [1:0] ac = m_step[p][w][k][1:0];
      if (ix == 3'd7) break;
      if (ix != 3'd6 && m_edge[p][ix] >= last) begin
        last = m_edge[p][ix];
        if (int'(m_edge[p][ix]) == s) begin
          case (ac)
            2'd0: begin exp_pin[p] = 1'b0; exp_oe[p] = 1'b1; end
            2'd1: begin exp_pin[p] = 1'b1; exp_oe[p] = 1'b1; end
            2'd2: exp_oe[p] = 1'b0;
            default: begin exp_pin[p] = ~exp_pin[p]; exp_oe[p] = 1'b1; end
          endcase
        end
      end
    end
  endtask

  // R11: address/data layout of configuration writes
  task automatic cfg_write(int p, logic [5:0] a, logic [4:0] d);
    cfg_addr = a;
    cfg_wdata = d;
    we_s[p] = 1'b1;
    @(negedge clk);
    we_s[p] = 1'b0;
    if (a[5]) begin
      if (a[2:0] < 3'd6) m_edge[p][a[2:0]] = d[2:0];
    end else begin
      m_step[p][a[4:2]][a[1:0]] = d;
    end
  endtask

  task automatic wr_step(int p, int w, int k, int ix, int ac);
    cfg_write(p, {1'b0, 3'(w), 2'(k)}, {3'(ix), 2'(ac)});
  endtask

  task automatic wr_edge(int p, int e, int pos);
    cfg_write(p, {1'b1, 2'b00, 3'(e)}, {2'b00, 3'(pos)});
  endtask

  task automatic sync_cycle();
    while (!cyc_s[0]) @(negedge clk);
  endtask

  // one tester cycle; entered at the falling edge inside slot 0
  task automatic run_cycle(int na, int nb, string tag);
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 2; p++) begin
        string t = (p == 0) ? tag : {tag, " R10"};
        chk("R2", "cyc_o", cyc_s[p], s == 0);
        chk(t, "pin_o", pin_s[p], exp_pin[p]);
        chk({t, " R12"}, "oe_o", oe_s[p], exp_oe[p]);
        chk("R7", "err_o", err_s[p], model_err(p, cur_w[p]));
      end
      for (int p = 0; p < 2; p++) model_slot(p, cur_w[p], s);
      if (s == 7) begin
        sel_s[0] = 3'(na);
        sel_s[1] = 3'(nb);
      end else begin
        sel_s[0] = 3'(s * 5 + 3);  // R3: ignored mid-cycle
        sel_s[1] = 3'(s * 3 + 6);
      end
      @(negedge clk);
    end
    cur_w[0] = na;
    cur_w[1] = nb;
  endtask

  task automatic program_arith(int p, int r);
    for (int e = 0; e < 6; e++) wr_edge(p, e, (e * (2 * r + 1) + r) % 8);
    wr_edge(p, 6, r % 8);  // R11: ignored edge numbers
    wr_edge(p, 7, (r + 3) % 8);
    for (int w = 1; w < 8; w++)
      for (int k = 0; k < 4; k++)
        wr_step(p, w, k, (w * 3 + k * r + r) % 8, (w * k + r) % 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int sa[16] = '{1, 2, 3, 3, 4, 5, 6, 6, 0, 6, 7, 1, 2, 4, 3, 0};
    for (int p = 0; p < 2; p++) begin
      sel_s[p] = 3'd0;
      we_s[p]  = 1'b0;
      exp_pin[p] = 1'b0;
      exp_oe[p]  = 1'b0;
      cur_w[p]   = 0;
      for (int e = 0; e < 6; e++) m_edge[p][e] = 3'd0;
      for (int w = 0; w < 8; w++)
        for (int k = 0; k < 4; k++) m_step[p][w][k] = 5'b11100;
    end

    repeat (3) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk("R1", "pin_o in reset", pin_s[p], 1'b0);
      chk("R1", "oe_o in reset", oe_s[p], 1'b0);
      chk("R1", "err_o in reset", err_s[p], 1'b0);
    end
    rst_n = 1'b1;
    chk("R1", "cyc_o after reset", cyc_s[0], 1'b1);
    chk("R1", "pin_o after reset", pin_s[0], 1'b0);

    // directed waveforms on pin A, arithmetic set on pin B
    wr_edge(0, 0, 0); wr_edge(0, 1, 2); wr_edge(0, 2, 3);
    wr_edge(0, 3, 5); wr_edge(0, 4, 6); wr_edge(0, 5, 7);
    wr_step(0, 1, 0, 1, 1); wr_step(0, 1, 1, 2, 0); wr_step(0, 1, 2, 7, 0);
    wr_step(0, 2, 0, 3, 1); wr_step(0, 2, 1, 4, 0); wr_step(0, 2, 2, 7, 0);   // R9 shift
    wr_step(0, 3, 0, 0, 3); wr_step(0, 3, 1, 0, 3);                           // R8 cancel
    wr_step(0, 3, 2, 5, 1); wr_step(0, 3, 3, 5, 2);                           // R8 R5
    wr_step(0, 4, 0, 3, 1); wr_step(0, 4, 1, 1, 0); wr_step(0, 4, 2, 4, 3);   // R7
    wr_step(0, 4, 3, 7, 0);
    wr_step(0, 5, 0, 6, 1); wr_step(0, 5, 1, 2, 1); wr_step(0, 5, 2, 7, 0);   // R7 R6
    wr_step(0, 5, 3, 0, 0);
    wr_step(0, 6, 0, 0, 1); wr_step(0, 6, 1, 5, 0); wr_step(0, 6, 2, 7, 0);   // R9 no dead slot
    wr_step(0, 7, 0, 2, 2); wr_step(0, 7, 1, 4, 0); wr_step(0, 7, 2, 7, 0);   // R4 release
    program_arith(1, 5);
    sync_cycle();
    for (int i = 0; i < 16; i++)
      run_cycle(sa[i], (i * 3 + 1) % 8, "R4 R5 R6 R8 R9");
    run_cycle(0, 0, "R12");

    // R9: move edges under fixed waveforms
    wr_edge(0, 1, 4); wr_edge(0, 2, 6);
    sync_cycle();
    for (int i = 0; i < 4; i++) run_cycle(1 + (i % 2), 6, "R9 R11");
    run_cycle(0, 0, "R12");

    for (int r = 1; r <= 3; r++) begin
      program_arith(0, r);
      program_arith(1, r + 4);
      sync_cycle();
      for (int i = 0; i < 24; i++)
        run_cycle((i * 5 + r) % 8, (i * 3 + 2 * r) % 8, "R3 R5 R6 R8");
      run_cycle(0, 0, "R12");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule